// File: doc/BRIEF.md
# Three-Format Instruction Execute Stage

This block is the single-cycle execute stage for a small integer subset of a 32-bit instruction set that uses fixed-width words in three layouts. Every layout keeps a 6-bit opcode in the top bits. The register-to-register layout and the immediate layout also share the positions of their two register fields. Each cycle the block reads the presented word and finds its layout from the opcode. It picks out the register numbers and widens the 16-bit immediate by the rule that the operation needs. It then computes the result and, when the instruction-valid input is high, writes the result into a 32-entry by 32-bit register file on the rising clock edge.

Register reads are combinational, so both source operands are visible at the ports in the same cycle as the word. A branch unit beside this stage uses the source-equality output to resolve compare-and-branch instructions. Words that fall outside the supported subset raise an illegal flag and change no register. This includes every jump-layout word.

Top module: `fmt_exec_unit`

## Requirements
- R1: After an active-low reset, every register of the file reads as zero.
- R2: Register 0 always reads as zero, and any write aimed at it is discarded.
- R3: When the opcode (bits 31..26) is 0, the function code in bits 5..0 selects the operation: 32 is add, 37 is bitwise or, and 42 is signed set-less-than. The sources are bits 25..21 and 20..16, and the result goes to the register in bits 15..11 on the next rising edge.
- R4: Opcode 8 adds the sign-extended immediate (bits 15..0) to the register in bits 25..21 and writes the register in bits 20..16. For example, the word 0x22D5FFCE subtracts 50 from register 22 and stores the result in register 21.
- R5: Opcode 10 writes 1 when the source is less than the sign-extended immediate as signed numbers, and 0 otherwise. The upper 31 result bits are always zero.
- R6: Opcode 11 sign-extends the immediate and then compares it with the source as unsigned numbers, writing 1 or 0.
- R7: Opcode 13 ORs the source with the immediate zero-extended to 32 bits.
- R8: Opcode 15 writes the immediate into bits 31..16 of the target register and clears bits 15..0.
- R9: Opcodes 2 and 3 (the jump layout), any other opcode besides 0, 8, 10, 11, 13 and 15, and any function code other than 32, 37 and 42 under opcode 0 raise illegal_o and leave every register unchanged.
- R10: While valid_i is low, no register changes and wr_en_o stays low.
- R11: src_equal_o is high exactly when the two source registers (bits 25..21 and 20..16) hold equal values, combinationally.
- R12: The shift-amount bits 10..6 of a register-layout word have no effect on the supported operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; register writes occur on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the register file |
| valid_i | input | 1 | The word on instr_i is to be executed this cycle |
| instr_i | input | 32 | Instruction word |
| rs_data_o | output | 32 | Value of the register named by bits 25..21 |
| rt_data_o | output | 32 | Value of the register named by bits 20..16 |
| result_o | output | 32 | Computed result for the current word |
| wr_en_o | output | 1 | A register other than 0 is written at the next rising edge |
| wr_addr_o | output | 5 | Destination register number |
| illegal_o | output | 1 | The word is outside the supported subset |
| src_equal_o | output | 1 | The two source registers hold equal values |

## Verification
A wrong register-file entry stays hidden until a later word names that register as a source. From then on it shows at once on rs_data_o or rt_data_o and on src_equal_o, and it spreads into result_o in the same cycle. The bench therefore reads back every written destination through the source ports on the cycle after the write. A decode fault shows up in the same cycle as the word itself, through illegal_o, wr_en_o, wr_addr_o or result_o. The vectors are chosen so that a wrong immediate extension gives a different value: an unsigned compare against 0x8000, an or-immediate with 0xFFFF, and an upper-immediate load of 0x8000.

// File: rtl/exu_pkg.sv
`timescale 1ns/1ps
package exu_pkg;

    localparam int INSN_W = 32;
    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int RIDX_W = 5;
    localparam int IMM_W  = 16;

    localparam int OPC_LSB = 26;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JAL   = 6'd3;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'd11;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_SLT = 6'd42;

    typedef enum logic [1:0] {
        FMT_REG,
        FMT_IMM,
        FMT_JMP
    } fmt_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_OR,
        ALU_SLT,
        ALU_SLTU,
        ALU_PASS_B
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN,
        EXT_ZERO,
        EXT_UPPER
    } ext_e;

    typedef struct packed {
        fmt_e                fmt;
        alu_op_e             op;
        logic                use_imm;
        ext_e                ext;
        logic [RIDX_W-1:0]   dst;
        logic                bad;
    } dec_s;

endpackage

// File: rtl/exu_decode.sv
`timescale 1ns/1ps
module exu_decode
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [INSN_W-1:0] instr_i,
    output dec_s              dec_o,
    output logic [RIDX_W-1:0] rs_idx_o,
    output logic [RIDX_W-1:0] rt_idx_o,
    output logic [XLEN-1:0]   imm_o
);

    localparam int PAD_W = XLEN - IMM_W;

    logic [OPC_W-1:0]  opc;
    logic [FN_W-1:0]   fn;
    logic [RIDX_W-1:0] rd_idx;
    logic [IMM_W-1:0]  imm16;
    dec_s              dec_d;

    assign opc      = instr_i[OPC_LSB +: OPC_W];
    assign rs_idx_o = instr_i[RS_LSB +: RIDX_W];
    assign rt_idx_o = instr_i[RT_LSB +: RIDX_W];
    assign rd_idx   = instr_i[RD_LSB +: RIDX_W];
    assign fn       = instr_i[FN_W-1:0];
    assign imm16    = instr_i[IMM_W-1:0];

    // Layout and operation decode
    always_comb begin
        dec_d         = '0;
        dec_d.fmt     = FMT_IMM;
        dec_d.op      = ALU_ADD;
        dec_d.use_imm = 1'b1;
        dec_d.ext     = EXT_SIGN;
        dec_d.dst     = rt_idx_o;
        dec_d.bad     = 1'b0;
        if (opc == OPC_REG) begin
            dec_d.fmt     = FMT_REG;
            dec_d.use_imm = 1'b0;
            dec_d.dst     = rd_idx;
            unique case (fn)
                FN_ADD:  dec_d.op = ALU_ADD;
                FN_OR:   dec_d.op = ALU_OR;
                FN_SLT:  dec_d.op = ALU_SLT;
                default: dec_d.bad = 1'b1;
            endcase
        end else if (opc == OPC_JMP || opc == OPC_JAL) begin
            dec_d.fmt = FMT_JMP;
            dec_d.bad = 1'b1;
        end else begin
            unique case (opc)
                OPC_ADDI:  dec_d.op = ALU_ADD;
                OPC_SLTI:  dec_d.op = ALU_SLT;
                OPC_SLTIU: dec_d.op = ALU_SLTU;
                OPC_ORI: begin
                    dec_d.op  = ALU_OR;
                    dec_d.ext = EXT_ZERO;
                end
                OPC_LUI: begin
                    dec_d.op  = ALU_PASS_B;
                    dec_d.ext = EXT_UPPER;
                end
                default: dec_d.bad = 1'b1;
            endcase
        end
    end

    // Immediate widening
    always_comb begin
        unique case (dec_d.ext)
            EXT_ZERO:  imm_o = {{PAD_W{1'b0}}, imm16};
            EXT_UPPER: imm_o = {imm16, {PAD_W{1'b0}}};
            default:   imm_o = {{PAD_W{imm16[IMM_W-1]}}, imm16};
        endcase
    end

    assign dec_o = dec_d;

endmodule

// File: rtl/exu_alu.sv
`timescale 1ns/1ps
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] y_o
);

    logic lt_signed;
    logic lt_unsigned;

    assign lt_signed   = $signed(a_i) < $signed(b_i);
    assign lt_unsigned = a_i < b_i;

    always_comb begin
        unique case (op_i)
            ALU_ADD:    y_o = a_i + b_i;
            ALU_OR:     y_o = a_i | b_i;
            ALU_SLT:    y_o = {{(XLEN-1){1'b0}}, lt_signed};
            ALU_SLTU:   y_o = {{(XLEN-1){1'b0}}, lt_unsigned};
            ALU_PASS_B: y_o = b_i;
            default:    y_o = '0;
        endcase
    end

endmodule

// File: rtl/exu_regfile.sv
`timescale 1ns/1ps
module exu_regfile #(
    parameter int XLEN   = 32,
    parameter int NREG   = 32,
    parameter int NPORTS = 2
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               we_i,
    input  logic [$clog2(NREG)-1:0]            waddr_i,
    input  logic [XLEN-1:0]                    wdata_i,
    input  logic [NPORTS-1:0][$clog2(NREG)-1:0] raddr_i,
    output logic [NPORTS-1:0][XLEN-1:0]        rdata_o
);

    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] mem_q [NREG];
    logic [XLEN-1:0] mem_d [NREG];

    always_comb begin
        mem_d = mem_q;
        if (we_i && waddr_i != '0) begin
            mem_d[waddr_i] = wdata_i;
        end
        mem_d[0] = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NREG; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        logic [AW-1:0] ra;
        assign ra         = raddr_i[p];
        assign rdata_o[p] = (ra == '0) ? '0 : mem_q[ra];
    end

endmodule

// File: rtl/fmt_exec_unit.sv
`timescale 1ns/1ps
module fmt_exec_unit
    import exu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [INSN_W-1:0] instr_i,
    output logic [XLEN-1:0]   rs_data_o,
    output logic [XLEN-1:0]   rt_data_o,
    output logic [XLEN-1:0]   result_o,
    output logic              wr_en_o,
    output logic [RIDX_W-1:0] wr_addr_o,
    output logic              illegal_o,
    output logic              src_equal_o
);

    localparam int AW = $clog2(NREG);

    typedef struct packed {
        logic            we;
        logic [AW-1:0]   addr;
        logic [XLEN-1:0] data;
    } wb_s;

    dec_s                    dec;
    logic [RIDX_W-1:0]       rs_idx;
    logic [RIDX_W-1:0]       rt_idx;
    logic [XLEN-1:0]         imm;
    logic [XLEN-1:0]         opnd_b;
    logic [XLEN-1:0]         alu_y;
    logic [1:0][AW-1:0]      rf_raddr;
    logic [1:0][XLEN-1:0]    rf_rdata;
    wb_s                     wb_d;

    exu_decode #(.XLEN(XLEN)) u_dec (
        .instr_i  (instr_i),
        .dec_o    (dec),
        .rs_idx_o (rs_idx),
        .rt_idx_o (rt_idx),
        .imm_o    (imm)
    );

    assign rf_raddr[0] = AW'(rs_idx);
    assign rf_raddr[1] = AW'(rt_idx);

    exu_regfile #(.XLEN(XLEN), .NREG(NREG), .NPORTS(2)) u_rf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wb_d.we),
        .waddr_i (wb_d.addr),
        .wdata_i (wb_d.data),
        .raddr_i (rf_raddr),
        .rdata_o (rf_rdata)
    );

    assign opnd_b = dec.use_imm ? imm : rf_rdata[1];

    exu_alu #(.XLEN(XLEN)) u_alu (
        .op_i (dec.op),
        .a_i  (rf_rdata[0]),
        .b_i  (opnd_b),
        .y_o  (alu_y)
    );

    // Write-back request for the coming edge
    always_comb begin
        wb_d      = '0;
        wb_d.addr = AW'(dec.dst);
        wb_d.data = alu_y;
        wb_d.we   = valid_i && !dec.bad && (dec.dst != '0);
    end

    assign rs_data_o   = rf_rdata[0];
    assign rt_data_o   = rf_rdata[1];
    assign result_o    = alu_y;
    assign wr_en_o     = wb_d.we;
    assign wr_addr_o   = dec.dst;
    assign illegal_o   = dec.bad;
    assign src_equal_o = rf_rdata[0] == rf_rdata[1];

endmodule

// File: rtl/exu_checker.sv
`timescale 1ns/1ps
module exu_checker #(
    parameter int XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            valid_i,
    input logic [5:0]      opc_i,
    input logic [4:0]      rs_idx_i,
    input logic [XLEN-1:0] rs_data_o,
    input logic [XLEN-1:0] rt_data_o,
    input logic [XLEN-1:0] result_o,
    input logic            wr_en_o,
    input logic [4:0]      wr_addr_o,
    input logic            illegal_o,
    input logic            src_equal_o
);

    logic past_ok_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok_q <= 1'b0;
        else         past_ok_q <= 1'b1;
    end

    p_zero_reads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rs_idx_i == 5'd0 |-> rs_data_o == '0);

    p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && $past(wr_en_o) && rs_idx_i == $past(wr_addr_o))
            |-> rs_data_o == $past(result_o));

    p_slt_bool_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opc_i == 6'd10 || opc_i == 6'd11) |-> result_o[XLEN-1:1] == '0);

    p_upper_low_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        opc_i == 6'd15 |-> result_o[15:0] == 16'd0);

    p_jump_illegal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opc_i == 6'd2 || opc_i == 6'd3) |-> illegal_o);

    p_no_write_illegal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> !wr_en_o);

    p_idle_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> !wr_en_o);

    p_equal_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_equal_o |-> rs_data_o == rt_data_o);

endmodule

bind fmt_exec_unit exu_checker #(.XLEN(XLEN)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .opc_i       (instr_i[31:26]),
    .rs_idx_i    (instr_i[25:21]),
    .rs_data_o   (rs_data_o),
    .rt_data_o   (rt_data_o),
    .result_o    (result_o),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .illegal_o   (illegal_o),
    .src_equal_o (src_equal_o)
);

// File: tb/fmt_exec_unit_tb.sv
`timescale 1ns/1ps
module fmt_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] instr = 32'd0;
    logic [31:0] rs_data, rt_data, result;
    logic        wr_en, illegal, src_eq;
    logic [4:0]  wr_addr;

    always #2 clk = ~clk;

    fmt_exec_unit u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .valid_i     (valid),
        .instr_i     (instr),
        .rs_data_o   (rs_data),
        .rt_data_o   (rt_data),
        .result_o    (result),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .illegal_o   (illegal),
        .src_equal_o (src_eq)
    );

    typedef struct {
        string       tag;
        logic        ill;
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] val;
    } exp_t;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] model [32];
    exp_t        sb [$];
    event        mon_ev;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int sh, input int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction

    // Expected outcome from the requirements
    function automatic exp_t predict(input logic [31:0] w, input string tag);
        exp_t        e;
        logic [31:0] a, b, sx;
        logic [4:0]  dst;
        e.tag = tag; e.ill = 1'b0; e.val = '0;
        a   = model[w[25:21]];
        b   = model[w[20:16]];
        sx  = {{16{w[15]}}, w[15:0]};
        dst = w[20:16];
        case (w[31:26])
            6'd0: begin
                dst = w[15:11];
                case (w[5:0])
                    6'd32:   e.val = a + b;
                    6'd37:   e.val = a | b;
                    6'd42:   e.val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: e.ill = 1'b1;
                endcase
            end
            6'd8:    e.val = a + sx;
            6'd10:   e.val = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            6'd11:   e.val = (a < sx) ? 32'd1 : 32'd0;
            6'd13:   e.val = a | {16'd0, w[15:0]};
            6'd15:   e.val = {w[15:0], 16'd0};
            default: e.ill = 1'b1;
        endcase
        e.addr = dst;
        e.wr   = !e.ill && dst != 5'd0;
        return e;
    endfunction

    // Driver: pushes the expectation, then the edge commits it
    task automatic issue(input logic [31:0] w, input string tag);
        exp_t e;
        @(negedge clk);
        instr = w;
        valid = 1'b1;
        e = predict(w, tag);
        sb.push_back(e);
        #1 -> mon_ev;
        @(posedge clk);
        if (e.wr) model[e.addr] = e.val;
        @(negedge clk);
        valid = 1'b0;
    endtask

    // Read two registers through the source ports
    task automatic peek(input int ra, input int rb, input string tag);
        @(negedge clk);
        valid = 1'b0;
        instr = enc_i(8, ra, rb, 0);
        #1;
        check({tag, " rs"}, rs_data, model[ra]);
        check({tag, " rt"}, rt_data, model[rb]);
        check({tag, " eq R11"}, {31'd0, src_eq}, {31'd0, model[ra] == model[rb]});
    endtask

    // Monitor: pops and compares as results appear
    initial begin
        forever begin
            exp_t e;
            @(mon_ev);
            e = sb.pop_front();
            check({e.tag, " illegal"}, {31'd0, illegal}, {31'd0, e.ill});
            check({e.tag, " wr_en"}, {31'd0, wr_en}, {31'd0, e.wr});
            if (e.wr) begin
                check({e.tag, " addr"}, {27'd0, wr_addr}, {27'd0, e.addr});
                check({e.tag, " result"}, result, e.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 32; i += 2) peek(i, i + 1, "R1 reset");

        issue(enc_i(8, 0, 22, 100), "R4 addi pos");
        issue(32'h22D5FFCE, "R4 addi neg");
        peek(21, 22, "R4 readback");

        issue(enc_i(15, 0, 1, 16'h8000), "R8 lui");
        peek(1, 0, "R8 readback");
        issue(enc_i(13, 1, 1, 16'hFFFF), "R7 ori");
        issue(enc_i(8, 0, 2, 16'hFFFF), "R4 addi minus1");
        peek(1, 2, "R7 readback");

        issue(enc_i(10, 1, 3, 0), "R5 slti neg");
        issue(enc_i(10, 22, 4, 50), "R5 slti false");
        issue(enc_i(11, 2, 5, 16'hFFFF), "R6 sltiu equal");
        issue(enc_i(15, 0, 7, 1), "R8 lui small");
        issue(enc_i(11, 7, 8, 16'h8000), "R6 sltiu sext");
        peek(3, 4, "R5 readback");
        peek(5, 8, "R6 readback");

        issue(enc_r(21, 22, 9, 0, 32), "R3 add");
        issue(enc_r(1, 22, 10, 0, 37), "R3 or");
        issue(enc_r(1, 22, 11, 0, 42), "R3 slt true");
        issue(enc_r(22, 1, 12, 0, 42), "R3 slt false");
        peek(9, 10, "R3 readback a");
        peek(11, 12, "R3 readback b");

        issue(enc_r(21, 22, 13, 7, 32), "R12 shamt add");
        peek(13, 9, "R12 readback");

        issue(enc_i(8, 0, 0, 5), "R2 write r0");
        issue(enc_r(22, 21, 0, 0, 32), "R2 add to r0");
        peek(0, 0, "R2 readback");

        issue(32'h08100001, "R9 jump");
        issue(32'h0C000010, "R9 jal");
        issue(enc_i(35, 0, 14, 9), "R9 bad opcode");
        issue(enc_r(22, 22, 14, 0, 0), "R9 bad funct");
        peek(14, 0, "R9 unchanged");

        @(negedge clk);
        valid = 1'b0;
        instr = enc_i(8, 0, 15, 7);
        #1;
        check("R10 wr_en idle", {31'd0, wr_en}, 32'd0);
        @(posedge clk);
        peek(15, 0, "R10 unchanged");

        issue(enc_i(8, 22, 16, 0), "R11 copy");
        peek(16, 22, "R11 equal");
        peek(16, 21, "R11 differ");

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule